// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for the data-movement phases of a bus controller. Software writes a 16-bit count as two bytes into staging registers. A DMA start strobe then copies the staged value into the live counter. On the same edge the block registers the burst length for the coming transfer. That length is the programmed count limited by the remaining transfer size, or by a fixed limit while command bytes are being gathered. A staged count of zero stands for the full 64K range.

While data moves, accepted beats count the live counter down. The count stops at zero and never wraps. When a burst finishes, the block either completes at once or waits, depending on the phase and on whether the attached device still has data to deliver. If it waits, completion comes when the device reports done. Completion sets the terminal-count status, raises the interrupt and clears the readable count. Software acknowledges the interrupt to lower it. The data movement itself happens outside this block.

Top module: `xfer_len_ctr`

## Requirements
- R1: The staged count is `{mid byte, low byte}`. A write with `cnt_lo_we` stores `cnt_wdata` as bits 7:0 and a write with `cnt_mid_we` stores it as bits 15:8. A write changes no output. One cycle after `dma_go`, `cnt_rd` shows the staged value as it stood before that edge.
- R2: A staged count of zero acts as 65536. `burst_len` is then limited only by the other operand, and the live count starts at 65536, which reads as 0 in the 16-bit `cnt_rd`.
- R3: If `cmd_phase` is high at `dma_go`, `burst_len` becomes min(effective count, 32) one cycle later.
- R4: If `cmd_phase` is low at `dma_go`, `burst_len` becomes min(effective count, |rem_size|) one cycle later. A negative `rem_size` means data out, a positive one means data in, and zero gives a length of 0.
- R5: `dma_go` clears `tc_stat` on the next cycle and also cancels any completion that is still waiting.
- R6: A `beat_valid` cycle without `dma_go` or completion lowers the live count by `beat_bytes`. If `beat_bytes` is larger than the count, the count goes to 0 and does not wrap.
- R7: `burst_done` with `cmd_phase` high, or with `rem_size` > 0, completes on the next cycle: `tc_stat`=1, `irq`=1 and `cnt_rd`=0.
- R8: `burst_done` in a data phase with `rem_size` <= 0 does not raise `irq`. Instead it arms a waiting completion, and the next `dev_done` carries it out as in R7. A `dev_done` with nothing waiting has no effect.
- R9: `irq_ack` lowers `irq` on the next cycle. If a completion happens in the same cycle, the completion wins.
- R10: After a synchronous reset, `cnt_rd`, `burst_len`, `tc_stat` and `irq` are all 0, and `dma_go` has priority over completion and beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_lo_we | input | 1 | Write strobe for the staged low count byte |
| cnt_mid_we | input | 1 | Write strobe for the staged middle count byte |
| cnt_wdata | input | 8 | Byte written into the staged count |
| dma_go | input | 1 | DMA start strobe: reload counter, compute burst length |
| cmd_phase | input | 1 | High while command bytes are being gathered |
| rem_size | input | 24 | Signed remaining size; negative means data out |
| beat_valid | input | 1 | A beat of bytes was accepted |
| beat_bytes | input | 8 | Bytes accepted on this beat |
| burst_done | input | 1 | The current burst has finished |
| dev_done | input | 1 | The device reports it has finished |
| irq_ack | input | 1 | Interrupt acknowledge |
| cnt_rd | output | 16 | Readable live count |
| burst_len | output | 17 | Burst length computed at the last `dma_go` |
| tc_stat | output | 1 | Terminal-count status |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach is a completion that is waiting for the device. To get there, `burst_done` must arrive in a data phase with a non-positive size. Then, before `dev_done`, the stimulus may or may not send a new `dma_go`, which cancels the wait. Directed steps build the plain waiting case first. After that, seeded random steps mix `burst_done`, `dev_done`, `dma_go` and acknowledges over sizes of both signs, so waits get cancelled, completed and overlapped with acknowledges.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;

    typedef enum logic [1:0] {
        FIN_NONE  = 2'd0,
        FIN_NOW   = 2'd1,
        FIN_DEFER = 2'd2
    } fin_kind_e;

    typedef struct packed {
        logic tc;
        logic irq;
        logic pend;
    } done_state_t;

    localparam int CMD_BYTE_LIMIT = 32;

    // decide how a burst-done strobe resolves
    function automatic fin_kind_e fin_kind(input logic strobe,
                                           input logic in_cmd,
                                           input logic dev_has_data);
        if (!strobe)
            return FIN_NONE;
        else if (in_cmd || dev_has_data)
            return FIN_NOW;
        else
            return FIN_DEFER;
    endfunction

endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
    parameter int CNT_W     = 16,
    parameter int SIZE_W    = 24,
    parameter int CMD_LIMIT = 32
) (
    input  logic [CNT_W-1:0]         count,
    input  logic                     in_cmd,
    input  logic signed [SIZE_W-1:0] size,
    output logic [CNT_W:0]           len
);
    localparam int LEN_W = CNT_W + 1;
    localparam int CMP_W = (LEN_W > SIZE_W) ? LEN_W : SIZE_W;

    logic [LEN_W-1:0]  eff;
    logic [SIZE_W-1:0] mag;
    logic [CMP_W-1:0]  eff_w, lim_w, sel_w;

    always_comb begin
        eff   = (count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count};
        mag   = size[SIZE_W-1] ? (-size) : size;
        eff_w = CMP_W'(eff);
        lim_w = in_cmd ? CMP_W'(CMD_LIMIT) : CMP_W'(mag);
        sel_w = (eff_w < lim_w) ? eff_w : lim_w;
        len   = sel_w[LEN_W-1:0];
    end

endmodule

// File: rtl/xfer_len_count.sv
module xfer_len_count #(
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_we,
    input  logic              mid_we,
    input  logic [7:0]        wdata,
    input  logic              load,
    input  logic              clear,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic [CNT_W-1:0]  staged,
    output logic [CNT_W-1:0]  cnt_rd
);
    localparam int HI_W = CNT_W - 8;
    localparam int REM_W = CNT_W + 1;

    logic [7:0]      stg_lo;
    logic [HI_W-1:0] stg_hi;
    logic [REM_W-1:0] remain;
    logic [REM_W-1:0] beat_ext;

    assign staged   = {stg_hi, stg_lo};
    assign cnt_rd   = remain[CNT_W-1:0];
    assign beat_ext = REM_W'(beat_bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_lo <= '0;
            stg_hi <= '0;
        end else begin
            if (lo_we)  stg_lo <= wdata;
            if (mid_we) stg_hi <= wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= (staged == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, staged};
        else if (clear)
            remain <= '0;
        else if (beat_valid)
            remain <= (remain > beat_ext) ? (remain - beat_ext) : '0;
    end

    // R6: a beat never makes the count grow (no wrap below zero)
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !load && !clear) |=> (remain <= $past(remain)));

    // R7: completion clears the live count
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> (remain == '0));

endmodule

// File: rtl/xfer_done_ctl.sv
module xfer_done_ctl
    import xfer_len_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic burst_done,
    input  logic dev_done,
    input  logic irq_ack,
    input  logic in_cmd,
    input  logic dev_has_data,
    output logic complete,
    output logic tc_stat,
    output logic irq
);
    done_state_t st, st_n;
    fin_kind_e   kind;

    assign kind     = fin_kind(burst_done, in_cmd, dev_has_data);
    assign complete = (kind == FIN_NOW) || (dev_done && st.pend);
    assign tc_stat  = st.tc;
    assign irq      = st.irq;

    always_comb begin
        st_n = st;
        if (go) begin
            st_n.tc   = 1'b0;
            st_n.pend = 1'b0;
            if (irq_ack) st_n.irq = 1'b0;
        end else if (complete) begin
            st_n.tc   = 1'b1;
            st_n.irq  = 1'b1;
            st_n.pend = 1'b0;
        end else begin
            if (kind == FIN_DEFER) st_n.pend = 1'b1;
            if (irq_ack)           st_n.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    // R5: a DMA start clears terminal count
    p_go_clears_tc_r5: assert property (@(posedge clk) disable iff (rst)
        go |=> !tc_stat);

    // R7: immediate completion raises status and interrupt
    p_immediate_r7: assert property (@(posedge clk) disable iff (rst)
        (burst_done && !go && (in_cmd || dev_has_data)) |=> (tc_stat && irq));

    // R8: a deferred burst end keeps the interrupt low
    p_defer_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (burst_done && !go && !in_cmd && !dev_has_data && !dev_done && !irq)
        |=> !irq);

    // R9: acknowledge without any completion lowers the interrupt
    p_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !burst_done && !dev_done) |=> !irq);

endmodule

// File: rtl/xfer_len_ctr.sv
module xfer_len_ctr #(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 24,
    parameter int BEAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cnt_lo_we,
    input  logic                     cnt_mid_we,
    input  logic [7:0]               cnt_wdata,
    input  logic                     dma_go,
    input  logic                     cmd_phase,
    input  logic signed [SIZE_W-1:0] rem_size,
    input  logic                     beat_valid,
    input  logic [BEAT_W-1:0]        beat_bytes,
    input  logic                     burst_done,
    input  logic                     dev_done,
    input  logic                     irq_ack,
    output logic [CNT_W-1:0]         cnt_rd,
    output logic [CNT_W:0]           burst_len,
    output logic                     tc_stat,
    output logic                     irq
);
    import xfer_len_pkg::*;

    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] staged;
    logic [LEN_W-1:0] len_next;
    logic [LEN_W-1:0] len_q;
    logic             complete;
    logic             has_data;

    assign has_data  = !rem_size[SIZE_W-1] && (rem_size != '0);
    assign burst_len = len_q;

    xfer_len_count #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) count_i (
        .clk        (clk),
        .rst        (rst),
        .lo_we      (cnt_lo_we),
        .mid_we     (cnt_mid_we),
        .wdata      (cnt_wdata),
        .load       (dma_go),
        .clear      (complete),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .staged     (staged),
        .cnt_rd     (cnt_rd)
    );

    xfer_len_calc #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .CMD_LIMIT(CMD_BYTE_LIMIT)) calc_i (
        .count  (staged),
        .in_cmd (cmd_phase),
        .size   (rem_size),
        .len    (len_next)
    );

    xfer_done_ctl done_i (
        .clk          (clk),
        .rst          (rst),
        .go           (dma_go),
        .burst_done   (burst_done),
        .dev_done     (dev_done),
        .irq_ack      (irq_ack),
        .in_cmd       (cmd_phase),
        .dev_has_data (has_data),
        .complete     (complete),
        .tc_stat      (tc_stat),
        .irq          (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)         len_q <= '0;
        else if (dma_go) len_q <= len_next;
    end

    // R3: in a command phase the burst never exceeds the byte limit
    p_cmd_cap_r3: assert property (@(posedge clk) disable iff (rst)
        (dma_go && cmd_phase) |=> (burst_len <= LEN_W'(CMD_BYTE_LIMIT)));

    // R1: the length holds between DMA starts
    p_len_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !dma_go |=> $stable(burst_len));

endmodule

// File: tb/xfer_len_ctr_tb_top.sv
`timescale 1ns/1ps
module xfer_len_ctr_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        cnt_lo_we, cnt_mid_we, dma_go, cmd_phase;
    logic [7:0]  cnt_wdata;
    logic signed [23:0] rem_size;
    logic        beat_valid, burst_done, dev_done, irq_ack;
    logic [7:0]  beat_bytes;
    logic [15:0] cnt_rd;
    logic [16:0] burst_len;
    logic        tc_stat, irq;

    xfer_len_ctr dut_i (
        .clk(clk), .rst(rst), .cnt_lo_we(cnt_lo_we), .cnt_mid_we(cnt_mid_we),
        .cnt_wdata(cnt_wdata), .dma_go(dma_go), .cmd_phase(cmd_phase),
        .rem_size(rem_size), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
        .burst_done(burst_done), .dev_done(dev_done), .irq_ack(irq_ack),
        .cnt_rd(cnt_rd), .burst_len(burst_len), .tc_stat(tc_stat), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_lo, m_mid, m_cnt, m_len;
    bit m_tc, m_irq, m_pend;

    function automatic int exp_len(int c, bit cmd, int r);
        int e;
        int l;
        e = (c == 0) ? 65536 : c;
        l = cmd ? 32 : ((r < 0) ? -r : r);
        return (e < l) ? e : l;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cnt_lo_we = 0; cnt_mid_we = 0; dma_go = 0; beat_valid = 0;
        burst_done = 0; dev_done = 0; irq_ack = 0;
    endtask

    task automatic step(string tag);
        int stg, r;
        bit fin;
        @(posedge clk);
        if (rst) begin
            m_lo = 0; m_mid = 0; m_cnt = 0; m_len = 0;
            m_tc = 0; m_irq = 0; m_pend = 0;
        end else begin
            stg = m_mid * 256 + m_lo;
            r = int'(rem_size);
            fin = (burst_done && (cmd_phase || r > 0)) || (dev_done && m_pend);
            if (dma_go) begin
                m_cnt = (stg == 0) ? 65536 : stg;
                m_len = exp_len(stg, cmd_phase, r);
                m_tc = 0; m_pend = 0;
                if (irq_ack) m_irq = 0;
            end else if (fin) begin
                m_cnt = 0; m_tc = 1; m_irq = 1; m_pend = 0;
            end else begin
                if (beat_valid) m_cnt = (m_cnt > int'(beat_bytes)) ? m_cnt - int'(beat_bytes) : 0;
                if (burst_done) m_pend = 1;
                if (irq_ack) m_irq = 0;
            end
            if (cnt_lo_we)  m_lo  = int'(cnt_wdata);
            if (cnt_mid_we) m_mid = int'(cnt_wdata);
        end
        @(negedge clk);
        chk(tag, "cnt_rd", int'(cnt_rd), m_cnt % 65536);
        chk(tag, "burst_len", int'(burst_len), m_len);
        chk(tag, "tc_stat", int'(tc_stat), int'(m_tc));
        chk(tag, "irq", int'(irq), int'(m_irq));
        idle_inputs();
    endtask

    task automatic load_count(int v, string tag);
        cnt_lo_we = 1; cnt_wdata = 8'(v); step(tag);
        cnt_mid_we = 1; cnt_wdata = 8'(v >> 8); step(tag);
    endtask

    task automatic go(bit cmd, int r, string tag);
        cmd_phase = cmd; rem_size = 24'(r); dma_go = 1; step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        cnt_wdata = 0; cmd_phase = 0; rem_size = 0; beat_bytes = 0;
        rst = 1;
        step("R10"); step("R10");
        rst = 0;
        step("R10");

        // R1: staged writes do not move outputs; go copies them
        load_count(16'h1234, "R1");
        go(0, 1000, "R4");
        chk("R1", "cnt_rd after go", int'(cnt_rd), 16'h1234);
        go(0, -300, "R4");
        chk("R4", "data out length", int'(burst_len), 300);
        go(0, 0, "R4");
        chk("R4", "zero size length", int'(burst_len), 0);
        go(1, 5000, "R3");
        chk("R3", "command cap", int'(burst_len), 32);
        load_count(5, "R1");
        go(1, 0, "R3");
        chk("R3", "small command count", int'(burst_len), 5);

        // R2: zero count means 65536
        load_count(0, "R2");
        go(0, 70000, "R2");
        chk("R2", "zero count length", int'(burst_len), 65536);
        go(0, -100000, "R2");
        beat_valid = 1; beat_bytes = 10; step("R6");
        chk("R2", "count after beat", int'(cnt_rd), 65526);

        // R6: saturation
        load_count(7, "R6");
        go(0, 50, "R6");
        beat_valid = 1; beat_bytes = 3; step("R6");
        beat_valid = 1; beat_bytes = 200; step("R6");
        chk("R6", "saturated at zero", int'(cnt_rd), 0);

        // R7 immediate, R9 acknowledge
        load_count(100, "R7");
        go(0, 40, "R7");
        rem_size = 40; burst_done = 1; step("R7");
        chk("R7", "irq immediate", int'(irq), 1);
        irq_ack = 1; step("R9");
        chk("R9", "irq lowered", int'(irq), 0);

        // R5: go clears tc
        go(0, 40, "R5");
        chk("R5", "tc cleared", int'(tc_stat), 0);

        // R8: deferred completion
        rem_size = -5; cmd_phase = 0; burst_done = 1; step("R8");
        chk("R8", "no irq while waiting", int'(irq), 0);
        step("R8");
        dev_done = 1; step("R8");
        chk("R8", "irq on device done", int'(irq), 1);
        irq_ack = 1; step("R9");
        dev_done = 1; step("R8");
        chk("R8", "stray device done", int'(irq), 0);

        // R9: completion beats acknowledge
        rem_size = 9; burst_done = 1; irq_ack = 1; step("R9");
        chk("R9", "completion wins", int'(irq), 1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 9);
            rem_size = 24'(int'($urandom_range(0, 160000)) - 80000);
            if ($urandom % 4 == 0) rem_size = 0;
            cmd_phase = ($urandom % 5 == 0);
            cnt_wdata = 8'($urandom);
            beat_bytes = 8'($urandom);
            case (op)
                0: begin cnt_lo_we = 1; step("R1"); end
                1: begin cnt_mid_we = 1; step("R1"); end
                2: begin dma_go = 1; step("R4"); end
                3: begin beat_valid = 1; step("R6"); end
                4: begin burst_done = 1; step("R7"); end
                5: begin dev_done = 1; step("R8"); end
                6: begin irq_ack = 1; step("R9"); end
                7: begin burst_done = 1; irq_ack = ($urandom % 2 == 0); dma_go = ($urandom % 3 == 0); step("R5"); end
                default: begin beat_valid = 1; dev_done = 1; step("R8"); end
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule